// File: doc/BRIEF.md
# Periodic Rate-Generator Timer Channel

This block is one channel of a periodic interval timer that divides a slow tick down into a regular interrupt event. It holds a 16-bit reload value and a 16-bit down counter. The counter moves only on clock edges where the tick enable is high. Every reload value N produces exactly one event every N ticks. An extra output tells a downstream interrupt latch when it may be cleared. Clearing is blocked from the moment of the event until the counter passes through its zero point, one tick later. With a 1.25 MHz tick, a value of 12500 gives a 10 ms period. With a 312.5 kHz tick, a value of 31250 gives 100 ms.

The channel is built around a four-state controller:
- `ST_IDLE`: nothing has been programmed yet.
- `ST_LOAD`: a value has been written and waits for the first tick.
- `ST_RUN`: the counter is decrementing.
- `ST_TERM`: the count sits at 1, the event has fired and clearing is blocked.

The transitions are:
- idle to load on a write.
- load to run, or load to term when the value is 1, on a tick. This tick copies the reload value into the counter.
- run to term on the tick that brings the count from 2 to 1.
- term to run, or term to term when the value is 1, on the next tick. This tick is the zero point, and it reloads the counter.

Software can rewrite the value at any time. The new value is used at the next load or reload. A value of 0 stands for 65536 ticks.

Top module: `rate_timer_channel`

## Requirements
- R1: After reset the count reads 0, the event output is low and the clear permit is high. Ticks do not move the count until a reload value has been written.
- R2: The first tick after the first write loads the count with the written value. A value of 0 loads as 0, which stands for 65536 ticks.
- R3: In the counting state each tick lowers the count by one. A count of 0 wraps to 65535.
- R4: The tick that leaves the count at 1 raises the event output for the following clock cycle only. While the event is high, the count reads 1.
- R5: The tick after the count has reached 1 is the zero point and reloads the count from the reload register. The events of a value N in 1..65535 are therefore N ticks apart, and those of a value of 0 are 65536 ticks apart.
- R6: The clear permit goes low together with the event and returns high on the zero-point tick. With a value of 1 it stays low once counting has begun.
- R7: A write does not change the count. The written value is used at the next load or reload. A write on the same edge as a reload leaves that reload using the value held before the edge.
- R8: On a clock edge with the tick enable low, the count does not change and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one clock cycle per tick |
| wr_en | input | 1 | Reload value write strobe |
| wr_data | input | 16 | Reload value (0 means 65536) |
| count_o | output | 16 | Current count |
| event_o | output | 1 | One-cycle periodic event |
| clr_ok_o | output | 1 | High when the downstream latch may be cleared |

## Verification
The count, the event and the clear permit all change on the same clock edge as the tick or write that causes them. Each is therefore due one edge after its stimulus. The bench drives inputs and samples outputs on the falling edge. After each rising edge it compares all three outputs with a reference that it steps once per edge from the requirements. Event spacing is also measured in ticks, for the values 1, 2, 3 and 0 with ticks on every edge, and for a value of 5 with randomly gapped ticks. Directed sequences cover the following cases:
- a write while counting;
- a write on the reload edge;
- long stretches of tick enable held low.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_TERM = 2'd3
    } tmr_state_e;
endpackage

// File: rtl/tmr_reload_reg.sv
module tmr_reload_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] reload_q,
    output logic         reload_is_one
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_q <= '0;
        else if (wr_en)
            reload_q <= wr_data;
    end

    assign reload_is_one = (reload_q == ONE);
endmodule

// File: rtl/tmr_down_core.sv
module tmr_down_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] reload_q,
    output logic [W-1:0] count_q,
    output logic         cnt_is_two
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (load)
            count_q <= reload_q;
        else if (dec)
            count_q <= count_q - ONE;
    end

    assign cnt_is_two = (count_q == TWO);
endmodule

// File: rtl/tmr_fsm.sv
module tmr_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic       cnt_is_two,
    input  logic       reload_is_one,
    output tmr_state_e state_q,
    output logic       load,
    output logic       dec,
    output logic       event_q,
    output logic       clr_ok
);
    tmr_state_e state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_en) state_d = ST_LOAD;
            ST_LOAD: if (tick_en) state_d = reload_is_one ? ST_TERM : ST_RUN;
            ST_RUN:  if (tick_en && cnt_is_two) state_d = ST_TERM;
            ST_TERM: if (tick_en) state_d = reload_is_one ? ST_TERM : ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // outputs: counter controls, clear permit, registered event
    always_comb begin
        load   = 1'b0;
        dec    = 1'b0;
        clr_ok = 1'b1;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: load = tick_en;
            ST_RUN:  dec  = tick_en;
            ST_TERM: begin
                load   = tick_en;
                clr_ok = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            event_q <= 1'b0;
        else
            event_q <= tick_en && (state_d == ST_TERM) && (state_q != ST_IDLE);
    end
endmodule

// File: rtl/rate_timer_channel.sv
module rate_timer_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic             event_o,
    output logic             clr_ok_o
);
    logic [CNT_W-1:0] reload_q;
    logic             reload_is_one;
    logic             cnt_is_two;
    logic             load;
    logic             dec;
    tmr_state_e       state_q;

    tmr_reload_reg #(.W(CNT_W)) u_reload (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .reload_q      (reload_q),
        .reload_is_one (reload_is_one)
    );

    tmr_down_core #(.W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .dec        (dec),
        .reload_q   (reload_q),
        .count_q    (count_o),
        .cnt_is_two (cnt_is_two)
    );

    tmr_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_en       (tick_en),
        .wr_en         (wr_en),
        .cnt_is_two    (cnt_is_two),
        .reload_is_one (reload_is_one),
        .state_q       (state_q),
        .load          (load),
        .dec           (dec),
        .event_q       (event_o),
        .clr_ok        (clr_ok_o)
    );
endmodule

// File: rtl/rate_timer_channel_chk.sv
module rate_timer_channel_chk
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_en,
    input logic [W-1:0] count_q,
    input logic         event_o,
    input logic         clr_ok_o,
    input logic [W-1:0] reload_q,
    input tmr_state_e   state_q
);
    p_idle_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (count_q == '0 && clr_ok_o && !event_o));

    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && state_q == ST_RUN) |=> (count_q == $past(count_q) - W'(1)));

    p_event_at_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> (count_q == W'(1)));

    p_event_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> $past(tick_en));

    p_reload_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && state_q == ST_TERM) |=> (count_q == $past(reload_q)));

    p_clear_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> !clr_ok_o);

    p_no_tick_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(count_q) && !event_o));
endmodule

bind rate_timer_channel rate_timer_channel_chk #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .count_q  (count_o),
    .event_o  (event_o),
    .clr_ok_o (clr_ok_o),
    .reload_q (reload_q),
    .state_q  (state_q)
);

// File: tb/rate_timer_channel_tb_top.sv
module rate_timer_channel_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXC = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] count_o;
    logic        event_o;
    logic        clr_ok_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // reference: 0 idle, 1 armed, 2 counting, 3 at one (event fired)
    int m_st, m_cnt, m_rel;
    bit m_evt;

    rate_timer_channel dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .count_o  (count_o),
        .event_o  (event_o),
        .clr_ok_o (clr_ok_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_period(int n);
        return (n == 0) ? 65536 : n;
    endfunction

    function automatic int after_tick(int c);
        return (c + 65535) % 65536;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic model_step(bit t, bit w, int d);
        int nc, ns;
        bit ev;
        nc = m_cnt; ns = m_st; ev = 0;
        case (m_st)
            0: if (w) ns = 1;
            1, 3: if (t) begin
                nc = m_rel;              // R2 load / R5 reload
                ns = (m_rel == 1) ? 3 : 2;
                ev = (m_rel == 1);
            end
            2: if (t) begin
                nc = after_tick(m_cnt);  // R3
                if (nc == 1) begin ns = 3; ev = 1; end
            end
            default: ;
        endcase
        if (w) m_rel = d;                // R7: old value used on same edge
        m_cnt = nc; m_st = ns; m_evt = ev;
    endtask

    task automatic compare_all();
        chk("R3 count", int'(count_o), m_cnt);
        chk("R4 event", int'(event_o), int'(m_evt));
        chk("R6 clear permit", int'(clr_ok_o), (m_st != 3) ? 1 : 0);
    endtask

    task automatic cycle(bit t, bit w, int d);
        tick_en = t; wr_en = w; wr_data = 16'(d);
        model_step(t, w, d);
        @(negedge clk);
        compare_all();
    endtask

    task automatic apply_reset();
        rst_n = 1'b0; tick_en = 0; wr_en = 0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_st = 0; m_cnt = 0; m_rel = 0; m_evt = 0;
        @(negedge clk);
    endtask

    task automatic measure(int n, bit rnd, string req);
        int seen, ticks, gap;
        bit t;
        apply_reset();
        cycle(0, 1, n);
        seen = 0; ticks = 0; gap = -1;
        while (seen < 2) begin
            t = rnd ? bit'($urandom % 2) : 1'b1;
            cycle(t, 0, 0);
            if (t) ticks++;
            if (event_o) begin
                seen++;
                if (seen == 1) ticks = 0; else gap = ticks;
            end
        end
        chk(req, gap, exp_period(n));
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);

        // R1: reset state and no counting before a write
        apply_reset();
        chk("R1 reset count", int'(count_o), 0);
        chk("R1 reset event", int'(event_o), 0);
        chk("R1 reset clear permit", int'(clr_ok_o), 1);
        repeat (6) cycle(1, 0, 0);
        chk("R1 idle ticks ignored", int'(count_o), 0);

        // R2: first tick after write loads the value
        cycle(0, 1, 5);
        chk("R2 write alone keeps count", int'(count_o), 0);
        cycle(1, 0, 0);
        chk("R2 load on first tick", int'(count_o), 5);

        // R8: ticks held low, writes ignored by the count
        for (int i = 0; i < 10; i++) begin
            cycle(0, (i == 4), 9);
            chk("R8 count held", int'(count_o), 5);
            chk("R8 no event", int'(event_o), 0);
        end

        // R7: write mid-count, then a write on the reload edge
        apply_reset();
        cycle(0, 1, 4);
        cycle(1, 0, 0);
        cycle(1, 0, 0);
        chk("R3 first decrement", int'(count_o), 3);
        cycle(0, 1, 7);
        chk("R7 write keeps count", int'(count_o), 3);
        cycle(1, 0, 0);
        cycle(1, 0, 0);
        chk("R4 event at one", int'(event_o), 1);
        chk("R6 clear blocked at event", int'(clr_ok_o), 0);
        cycle(1, 1, 9);
        chk("R7 reload uses prior value", int'(count_o), 7);
        chk("R6 clear permitted after zero", int'(clr_ok_o), 1);
        chk("R4 event one cycle", int'(event_o), 0);
        repeat (6) cycle(1, 0, 0);
        cycle(1, 0, 0);
        chk("R7 new value at next reload", int'(count_o), 9);

        // R5: event spacing
        measure(3, 0, "R5 period N=3");
        measure(1, 0, "R5 period N=1");
        chk("R6 clear stays low N=1", int'(clr_ok_o), 0);
        measure(2, 0, "R5 period N=2");
        measure(5, 1, "R5 R8 period N=5 gapped ticks");
        measure(0, 0, "R5 period N=0 is 65536");

        // constrained random mix
        apply_reset();
        cycle(0, 1, 3);
        for (int i = 0; i < 5000; i++) begin
            bit t, w;
            int d;
            t = ($urandom % 100) < 60;
            w = ($urandom % 100) < 3;
            d = (($urandom % 10) == 0) ? int'($urandom % 65536) : int'($urandom % 8);
            cycle(t, w, d);
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (MAXC) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule